// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that owns a 16-pin quasi-bidirectional port. A bus controller writes bytes that land in an output latch and reads bytes that reflect the levels present on the pins. There is no direction control. A pin whose latch bit is 0 is pulled low hard. A pin whose latch bit is 1 is held high by a weak pull-up and can then be used as an input. A freshly written 1 also gets a short strong pull-up pulse so that a heavily loaded line rises quickly.

The block runs on a system clock. The SCL and SDA inputs arrive already synchronised, and the block drives an open-drain pull-low request for SDA. Three strap pins set the device address. Each pin may be tied low, tied high, tied to SCL or tied to SDA, and each is presented to the block as a 2-bit code. Bytes after the address alternate between the low and the high half of the port, for as long as the controller keeps transferring.

Top module: `qbio_expander`

## Requirements
- R1: While reset is low, and in the first cycle after it, every latch bit is 1. This gives `weak_up` all ones, `strong_dn` all zeros, `boost_up` all zeros and `sda_pull_low` low.
- R2: Each strap is encoded in 2 bits: bit 1 is 1 when the pin is tied to a bus line, and bit 0 is 1 when it is tied to the high rail or to SDA. `strap_code[5:4]` is strap 2 and `strap_code[1:0]` is strap 0. The upper four bits of the 8-bit address come from the three bus-tie bits {s2,s1,s0}: 0→0x4, 1→0x5, 2→0x2, 3→0x3, 4→0xC, 5→0xE, 6→0xA, 7→0xB. Address bits 3..1 are the level bits of straps 2, 1, 0, and bit 0 is the R/W bit. With all straps at the low rail, the write address is 0x40.
- R3: The strap codes are captured once, in the first cycle after reset. Later changes to them do not alter the address until the next reset.
- R4: When the address byte matches, SDA is pulled low for the ninth clock. When it does not match, nothing is acknowledged and the following bytes are ignored until the next START.
- R5: An R/W bit of 1 selects read and 0 selects write. A read does not change the latch.
- R6: Written bytes go to bits 7..0, then to bits 15..8, and this alternation repeats without limit.
- R7: A written byte reaches the latch at the rising SCL edge of its acknowledge clock, and not before.
- R8: For each pin, latch 1 gives weak pull-up only, and latch 0 gives strong pull-down only.
- R9: The pins written with 1 get `boost_up` from the acknowledge rising edge until the next SCL falling edge. Pins written with 0 never get it.
- R10: Read bytes alternate the same way, starting with pins 7..0.
- R11: Each read byte is sampled from `port_in` at the SCL rising edge of the acknowledge clock that comes before it. A NACK from the controller ends the read and releases SDA.
- R12: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) both return the byte pointer to the low half. A repeated START begins a new address phase.
- R13: The general-call address 0x00 and the device-ID address 0xF8/0xF9 are never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| strap_code | input | 6 | Three 2-bit strap codes, strap 2 in the top pair |
| port_in | input | 16 | Levels observed on the port pins |
| sda_pull_low | output | 1 | Request to pull SDA low |
| weak_up | output | 16 | Per-pin weak pull-up enable |
| strong_dn | output | 16 | Per-pin strong pull-down enable |
| boost_up | output | 16 | Per-pin brief strong pull-up enable |

## Verification
The bench tests several points where a wrong design fails in a visible way. It checks that the latch does not move during the eighth data bit; a design that updates early would show the new byte before the acknowledge. It checks that a third written byte wraps back to the low half, which a design with a non-repeating pointer would drop. It checks that STOP and repeated START reset the pointer, otherwise a later byte would land in the high half. It checks that a read byte keeps the pin value taken at the acknowledge clock even if the pins change afterwards. It also tests a non-power-of-two strap mix, an address change after reset that must have no effect, the reserved addresses, and whether the boost pulse ends at the next falling SCL edge.

// File: rtl/qbio_pkg.sv
// qbio_pkg: shared types and the strap-to-address function for the
// quasi-bidirectional port expander. Assumes three straps of 2 bits each.
package qbio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } ser_state_t;

    localparam int STRAP_N = 3;
    localparam int STRAP_W = 2 * STRAP_N;
    localparam int DEV_ADDR_W = 7;

    // Build the 7-bit device address from three strap codes.
    function automatic logic [DEV_ADDR_W-1:0] strap_to_addr(input logic [STRAP_W-1:0] codes);
        logic [2:0] tie_bus;
        logic [2:0] lvl;
        logic [3:0] upper;
        tie_bus = {codes[5], codes[3], codes[1]};
        lvl     = {codes[4], codes[2], codes[0]};
        case (tie_bus)
            3'd1:    upper = 4'h5;
            3'd2:    upper = 4'h2;
            3'd3:    upper = 4'h3;
            3'd4:    upper = 4'hC;
            3'd5:    upper = 4'hE;
            3'd6:    upper = 4'hA;
            3'd7:    upper = 4'hB;
            default: upper = 4'h4;
        endcase
        return {upper, lvl};
    endfunction

endpackage

// File: rtl/qbio_bus_cond.sv
// qbio_bus_cond: detects SCL edges and START/STOP from synchronised bus
// levels. Assumes scl_i/sda_i are already free of metastability.
module qbio_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Hold the previous bus levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and bus conditions from current versus previous levels.
    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/qbio_strap_addr.sv
// qbio_strap_addr: captures the strap codes once after reset and forms the
// device address. Assumes straps are stable at reset release.
module qbio_strap_addr
    import qbio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRAP_W-1:0]    strap_code,
    output logic [DEV_ADDR_W-1:0] dev_addr,
    output logic                  addr_valid
);

    localparam logic [DEV_ADDR_W-1:0] RSV_GCALL = 7'h00;
    localparam logic [DEV_ADDR_W-1:0] RSV_DEVID = 7'h7C;

    logic                 captured;
    logic [STRAP_W-1:0]   code_q;

    // Sample the straps in the first cycle out of reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            captured <= 1'b0;
            code_q   <= '0;
        end else if (!captured) begin
            captured <= 1'b1;
            code_q   <= strap_code;
        end
    end

    // Translate codes and refuse reserved addresses.
    always_comb begin
        dev_addr   = strap_to_addr(code_q);
        addr_valid = captured && (dev_addr != RSV_GCALL) && (dev_addr != RSV_DEVID);
    end

endmodule

// File: rtl/qbio_serial_fsm.sv
// qbio_serial_fsm: byte-level target engine. Shifts address and data bits,
// acknowledges, steps the half pointer and shifts read data out. Assumes
// edge/condition strobes are single-cycle pulses from qbio_bus_cond.
module qbio_serial_fsm
    import qbio_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int NUM_HALVES = 2,
    parameter int PORT_W     = BYTE_W * NUM_HALVES,
    parameter int HW         = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic                  sda_i,
    input  logic [DEV_ADDR_W-1:0] dev_addr,
    input  logic                  addr_valid,
    input  logic [PORT_W-1:0]     rd_word,
    output logic                  wr_en,
    output logic [HW-1:0]         wr_half,
    output logic [BYTE_W-1:0]     wr_byte,
    output logic                  sda_pull_low
);

    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST_BIT  = CW'(BYTE_W - 1);
    localparam logic [HW-1:0] LAST_HALF = HW'(NUM_HALVES - 1);

    ser_state_t        state;
    logic [CW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [HW-1:0]     half;
    logic              pending;
    logic              drive;
    logic [HW-1:0]     half_nxt;
    logic [BYTE_W-1:0] rd_byte;

    // Pointer successor and the byte selected for reading.
    always_comb begin
        half_nxt = (half == LAST_HALF) ? '0 : half + HW'(1);
        rd_byte  = rd_word[half*BYTE_W +: BYTE_W];
    end

    // Write strobe at the rising edge of a write acknowledge clock.
    always_comb begin
        wr_en   = (state == ST_WACK) && scl_rise;
        wr_half = half;
        wr_byte = shreg;
    end

    assign sda_pull_low = drive;

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            half    <= '0;
            pending <= 1'b0;
            drive   <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            half    <= '0;
            pending <= 1'b0;
            drive   <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            half    <= '0;
            pending <= 1'b0;
            drive   <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + CW'(1);
                        if (bit_cnt == LAST_BIT) pending <= 1'b1;
                    end else if (scl_fall && pending) begin
                        pending <= 1'b0;
                        if (state == ST_WDATA) begin
                            state <= ST_WACK;
                            drive <= 1'b1;
                        end else if (addr_valid && shreg[BYTE_W-1:1] == dev_addr) begin
                            state <= ST_AACK;
                            drive <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_rise && shreg[0]) begin
                        txreg <= rd_byte;
                        half  <= half_nxt;
                    end else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (shreg[0]) begin
                            state <= ST_RDATA;
                            drive <= ~txreg[BYTE_W-1];
                        end else begin
                            state <= ST_WDATA;
                            drive <= 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_rise) begin
                        half <= half_nxt;
                    end else if (scl_fall) begin
                        state   <= ST_WDATA;
                        drive   <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            state <= ST_RACK;
                            drive <= 1'b0;
                        end else begin
                            txreg   <= {txreg[BYTE_W-2:0], 1'b0};
                            drive   <= ~txreg[BYTE_W-2];
                            bit_cnt <= bit_cnt + CW'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (!sda_i) begin
                            txreg   <= rd_byte;
                            half    <= half_nxt;
                            pending <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (scl_fall && pending) begin
                        pending <= 1'b0;
                        state   <= ST_RDATA;
                        drive   <= ~txreg[BYTE_W-1];
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/qbio_pin_bank.sv
// qbio_pin_bank: output latch and per-pin drive enables. One latch segment
// per port half; a written 1 raises a boost that the next SCL fall clears.
module qbio_pin_bank #(
    parameter int BYTE_W     = 8,
    parameter int NUM_HALVES = 2,
    parameter int PORT_W     = BYTE_W * NUM_HALVES,
    parameter int HW         = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HW-1:0]     wr_half,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              scl_fall,
    output logic [PORT_W-1:0] weak_up,
    output logic [PORT_W-1:0] strong_dn,
    output logic [PORT_W-1:0] boost_up
);

    logic [PORT_W-1:0] latch;
    logic [PORT_W-1:0] boost;

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        logic [BYTE_W-1:0] lat_q;
        logic [BYTE_W-1:0] bst_q;

        // Update this half on its write strobe; end the boost on SCL fall.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q <= '1;
                bst_q <= '0;
            end else if (wr_en && wr_half == HW'(g)) begin
                lat_q <= wr_byte;
                bst_q <= wr_byte;
            end else if (scl_fall) begin
                bst_q <= '0;
            end
        end

        assign latch[g*BYTE_W +: BYTE_W] = lat_q;
        assign boost[g*BYTE_W +: BYTE_W] = bst_q;
    end

    // Per-pin drive selection from the latch.
    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        assign weak_up[p]   = latch[p];
        assign strong_dn[p] = ~latch[p];
        assign boost_up[p]  = boost[p] & latch[p];
    end

endmodule

// File: rtl/qbio_expander.sv
// qbio_expander: top of the quasi-bidirectional I2C port expander. Wires the
// bus condition detector, strap address decoder, serial engine and pin bank.
// Assumes synchronised SCL/SDA and port_in levels.
module qbio_expander
    import qbio_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int NUM_HALVES = 2,
    parameter int PORT_W     = BYTE_W * NUM_HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [5:0]        strap_code,
    input  logic [PORT_W-1:0] port_in,
    output logic              sda_pull_low,
    output logic [PORT_W-1:0] weak_up,
    output logic [PORT_W-1:0] strong_dn,
    output logic [PORT_W-1:0] boost_up
);

    localparam int HW = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;

    logic                  scl_rise;
    logic                  scl_fall;
    logic                  start_det;
    logic                  stop_det;
    logic [DEV_ADDR_W-1:0] dev_addr;
    logic                  addr_valid;
    logic                  wr_en;
    logic [HW-1:0]         wr_half;
    logic [BYTE_W-1:0]     wr_byte;

    qbio_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    qbio_strap_addr u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_code (strap_code),
        .dev_addr   (dev_addr),
        .addr_valid (addr_valid)
    );

    qbio_serial_fsm #(
        .BYTE_W     (BYTE_W),
        .NUM_HALVES (NUM_HALVES),
        .PORT_W     (PORT_W),
        .HW         (HW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_i        (sda_i),
        .dev_addr     (dev_addr),
        .addr_valid   (addr_valid),
        .rd_word      (port_in),
        .wr_en        (wr_en),
        .wr_half      (wr_half),
        .wr_byte      (wr_byte),
        .sda_pull_low (sda_pull_low)
    );

    qbio_pin_bank #(
        .BYTE_W     (BYTE_W),
        .NUM_HALVES (NUM_HALVES),
        .PORT_W     (PORT_W),
        .HW         (HW)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_half   (wr_half),
        .wr_byte   (wr_byte),
        .scl_fall  (scl_fall),
        .weak_up   (weak_up),
        .strong_dn (strong_dn),
        .boost_up  (boost_up)
    );

endmodule

// File: rtl/qbio_expander_chk.sv
// qbio_expander_chk: temporal checks on the expander ports, bound to the top.
module qbio_expander_chk #(
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_pull_low,
    input logic [PORT_W-1:0] weak_up,
    input logic [PORT_W-1:0] strong_dn,
    input logic [PORT_W-1:0] boost_up
);

    logic scl_d;
    logic sda_d;

    // Previous bus levels seen by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
        end
    end

    // R1: reset forces all-high latch, no boost, SDA released.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (weak_up == '1 && boost_up == '0 && !sda_pull_low));

    // R7: the latch only moves on an SCL rising edge.
    a_r7_latch_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_i && !scl_d) |=> $stable(weak_up));

    // R9: boost never on a pin that is pulled down.
    a_r9_boost_high_only: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_up & strong_dn) == '0);

    // R9: boost ends at an SCL falling edge.
    a_r9_boost_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_d && !scl_i) |=> (boost_up == '0));

    // R12: STOP releases SDA.
    a_r12_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_d && scl_i && !sda_d && sda_i) |=> !sda_pull_low);

endmodule

bind qbio_expander qbio_expander_chk #(.PORT_W(PORT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .sda_pull_low (sda_pull_low),
    .weak_up      (weak_up),
    .strong_dn    (strong_dn),
    .boost_up     (boost_up)
);

// File: tb/sim_qbio_expander.sv
module sim_qbio_expander;

    localparam int Q = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        m_scl;
    logic        m_sda;
    logic [5:0]  strap;
    logic [15:0] pins;
    logic        sda_pl;
    logic [15:0] wu;
    logic [15:0] sd;
    logic [15:0] bu;
    logic        sda_bus;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pl;

    qbio_expander u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .strap_code   (strap),
        .port_in      (pins),
        .sda_pull_low (sda_pl),
        .weak_up      (wu),
        .strong_dn    (sd),
        .boost_up     (bu)
    );

    typedef struct {
        logic [31:0] v;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] act_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    item_t       mon_e;
    logic [31:0] mon_a;

    // Driver side: record an expected value.
    task automatic expect_v(input string tag, input logic [31:0] v);
        item_t it;
        it.v   = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Observer side: record what the design produced.
    task automatic observe(input logic [31:0] v);
        act_q.push_back(v);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        expect_v(tag, exp);
        observe(act);
    endtask

    // Monitor: pair expectations with observations in order.
    always @(posedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_a = act_q.pop_front();
            n_cmp++;
            if (mon_a !== mon_e.v) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", mon_e.tag, mon_a, mon_e.v);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    // Controller write of one byte; reports ack, pre-ack latch and boost.
    task automatic send_byte(input logic [7:0] b, output logic ack,
                             output logic [15:0] wu_pre, output logic [15:0] bst,
                             output logic [15:0] bst_after);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
        wu_pre = wu;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = sda_bus;
        bst = bu;
        tick(Q);
        m_scl = 1'b0; tick(Q);
        bst_after = bu;
    endtask

    // Controller read of one byte, then ACK (mack=1) or NACK.
    task automatic recv_byte(input logic mack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_bus};
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ~mack; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick(3);
    endtask

    logic        ack;
    logic [15:0] wpre;
    logic [15:0] bst;
    logic [15:0] bsta;
    logic [7:0]  rb;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        m_scl = 1'b1;
        m_sda = 1'b1;
        strap = 6'b00_00_00;
        pins  = 16'h0000;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1 reset state
        chk("R1 weak_up", wu, 16'hFFFF);
        chk("R1 strong_dn", sd, 16'h0000);
        chk("R1 boost", bu, 16'h0000);
        chk("R1 sda", sda_pl, 0);

        // R2/R4/R6/R7/R8/R9 write sequence at 0x40
        bus_start();
        send_byte(8'h40, ack, wpre, bst, bsta);
        chk("R2 R4 address ack", ack, 0);
        send_byte(8'hA5, ack, wpre, bst, bsta);
        chk("R7 latch before ack", wpre, 16'hFFFF);
        chk("R6 low half", wu, 16'hFFA5);
        chk("R8 strong_dn", sd, 16'h005A);
        chk("R9 boost during ack", bst, 16'h00A5);
        chk("R9 boost after fall", bsta, 16'h0000);
        send_byte(8'h3C, ack, wpre, bst, bsta);
        chk("R6 high half", wu, 16'h3CA5);
        chk("R9 boost high half", bst, 16'h3C00);
        send_byte(8'hF0, ack, wpre, bst, bsta);
        chk("R6 wrap to low half", wu, 16'h3CF0);
        bus_stop();

        // R12 STOP and repeated START reset the pointer
        bus_start();
        send_byte(8'h40, ack, wpre, bst, bsta);
        send_byte(8'h0F, ack, wpre, bst, bsta);
        chk("R12 after stop low half", wu, 16'h3C0F);
        bus_start();
        send_byte(8'h40, ack, wpre, bst, bsta);
        chk("R12 restart address ack", ack, 0);
        send_byte(8'h11, ack, wpre, bst, bsta);
        chk("R12 restart low half", wu, 16'h3C11);
        bus_stop();

        // R4 foreign address ignored
        bus_start();
        send_byte(8'h42, ack, wpre, bst, bsta);
        chk("R4 foreign nack", ack, 1);
        send_byte(8'h00, ack, wpre, bst, bsta);
        chk("R4 ignored data nack", ack, 1);
        chk("R4 latch untouched", wu, 16'h3C11);
        bus_stop();

        // R13 reserved addresses
        bus_start();
        send_byte(8'h00, ack, wpre, bst, bsta);
        chk("R13 general call nack", ack, 1);
        bus_stop();
        bus_start();
        send_byte(8'hF8, ack, wpre, bst, bsta);
        chk("R13 device id nack", ack, 1);
        bus_stop();

        // R5/R10/R11 read sequence
        pins = 16'h1234;
        bus_start();
        send_byte(8'h41, ack, wpre, bst, bsta);
        chk("R5 read address ack", ack, 0);
        expect_v("R10 read low", 32'h34);
        expect_v("R10 read high", 32'h12);
        expect_v("R10 read wrap", 32'h34);
        recv_byte(1'b1, rb); observe(rb);
        recv_byte(1'b1, rb); observe(rb);
        recv_byte(1'b0, rb); observe(rb);
        chk("R11 release after nack", sda_pl, 0);
        bus_stop();
        chk("R5 read leaves latch", wu, 16'h3C11);

        // R11 sample point at the acknowledge clock
        pins = 16'hAAAA;
        bus_start();
        send_byte(8'h41, ack, wpre, bst, bsta);
        pins = 16'h5555;
        expect_v("R11 byte held from ack", 32'hAA);
        expect_v("R11 next byte from ack", 32'h55);
        recv_byte(1'b1, rb); observe(rb);
        recv_byte(1'b0, rb); observe(rb);
        bus_stop();

        // R2/R1 strap mix and mid-run reset
        strap = 6'b10_01_11;
        do_reset();
        chk("R1 reset again", wu, 16'hFFFF);
        bus_start();
        send_byte(8'hE6, ack, wpre, bst, bsta);
        chk("R2 strap mix ack", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h40, ack, wpre, bst, bsta);
        chk("R2 old address nack", ack, 1);
        bus_stop();

        // R3 straps captured once
        strap = 6'b01_10_00;
        tick(4);
        bus_start();
        send_byte(8'hE6, ack, wpre, bst, bsta);
        chk("R3 address kept", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h28, ack, wpre, bst, bsta);
        chk("R3 new strap ignored", ack, 1);
        bus_stop();
        do_reset();
        bus_start();
        send_byte(8'h28, ack, wpre, bst, bsta);
        chk("R2 R3 new strap after reset", ack, 0);
        bus_stop();

        tick(5);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard actual=%0d/%0d expected=0/0", exp_q.size(), act_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule